// File: doc/BRIEF.md
# Pipelined Ones-Counting Thermometer Decoder

This block turns the 63-bit output word of a bank of comparators into the 6-bit binary count of its set bits. A clean thermometer code of level k (bits 0 through k-1 set, bit 0 lowest) therefore decodes to k. The decoder counts ones and does not look for the transition point. A bubble, meaning a stray 0 below the transition or a stray 1 above it, moves the result by exactly one wherever it sits in the word. A bubble far from the transition can never cause a large jump in the code.

The count is formed by a carry-save tree built only from full adders. Six adder levels shrink the 63 inputs to nine weighted partial bits. A short ripple of three full adders then combines those bits by weight into the binary result. There is a register after every two adder levels and one on the output, so the block has four register stages. It takes a new word on every clock with no stall. A qualifier travels down the pipeline beside the data. A word presented with its qualifier low does not load any stage, so the output keeps the last valid count.

Top module: `therm_ones_decoder`

## Requirements
- R1: While `rst_n` is low, and after its release until the first qualified result arrives, `count_vld` is 0 and `count_out` is 0.
- R2: For every qualified word, `count_out` equals the number of set bits among `therm_in[62:0]`, whatever their positions.
- R3: A word sampled with `therm_vld` high at some rising edge produces its result on the fourth rising edge, counting the sampling edge as the first, with `count_vld` high for exactly one cycle.
- R4: Qualified words may arrive on consecutive cycles without limit, and each yields its own result in order, one per cycle.
- R5: A word sampled with `therm_vld` low is ignored: it produces no `count_vld` pulse, and `count_out` keeps the previous qualified result.
- R6: The all-zero word decodes to 0 and the all-one word decodes to 63.
- R7: Each clean thermometer code of level k (bits 0..k-1 set, others clear) decodes to k, for every k from 0 to 63.
- R8: A level-k code with one bit at position p inverted decodes to k-1 when p < k and to k+1 when p >= k, for every k and p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_in | input | 63 | Comparator word, bit 0 is the lowest reference level |
| therm_vld | input | 1 | Qualifies `therm_in` in this cycle |
| count_out | output | 6 | Binary count of ones of the qualified word |
| count_vld | output | 1 | Marks the cycle in which `count_out` carries a new result |

## Verification
Every result is due on the fourth rising edge, counting the edge that sampled its word as the first. An unqualified word is due nowhere, and the previous value must stay on the output. The bench drives inputs on falling edges and pushes each word's expected count into a four-deep expectation line. On every falling edge it compares both outputs with the entry that has just left that line. The check therefore lands half a cycle after the edge on which the result must appear, so a result that arrives one cycle early or one cycle late fails at the tagged entry. The bench sweeps every clean level, every single bubble at every level and position, random multi-bubble words with random gaps in the qualifier, and long unbroken bursts.

// File: rtl/tdec_pkg.sv
package tdec_pkg;
    // Output code width; the input word holds 2**CODE_W - 1 comparator bits.
    localparam int unsigned CODE_W  = 6;
    localparam int unsigned THERM_W = (1 << CODE_W) - 1;

    // Fixed reduction schedule for 63 inputs: triples handled per weight and level.
    localparam int unsigned L1_TRI  = THERM_W / 3;       // 21
    localparam int unsigned L2_TRI  = L1_TRI / 3;        // 7

    // Widths of the carry-save snapshots held in each register stage.
    localparam int unsigned S1_W0 = L2_TRI;              // weight 1
    localparam int unsigned S1_W1 = 2 * L2_TRI;          // weight 2
    localparam int unsigned S1_W2 = L2_TRI;              // weight 4
    localparam int unsigned S1_W  = S1_W0 + S1_W1 + S1_W2;

    localparam int unsigned S2_W0 = 1;
    localparam int unsigned S2_W1 = 5;
    localparam int unsigned S2_W2 = 5;
    localparam int unsigned S2_W3 = 4;
    localparam int unsigned S2_W  = S2_W0 + S2_W1 + S2_W2 + S2_W3;

    localparam int unsigned S3_W0 = 1;
    localparam int unsigned S3_W1 = 1;
    localparam int unsigned S3_W2 = 3;
    localparam int unsigned S3_W3 = 2;
    localparam int unsigned S3_W4 = 2;
    localparam int unsigned S3_W  = S3_W0 + S3_W1 + S3_W2 + S3_W3 + S3_W4;

    // Number of register stages from input to output.
    localparam int unsigned LATENCY = 4;
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic s,
    output logic co
);
    logic ab_x;

    assign ab_x = a ^ b;
    assign s    = ab_x ^ c;
    assign co   = (a & b) | (c & ab_x);
endmodule

// File: rtl/csa_row.sv
module csa_row #(
    parameter int unsigned TRI = 1
) (
    input  logic [3*TRI-1:0] bits,
    output logic [TRI-1:0]   sum,
    output logic [TRI-1:0]   carry
);
    for (genvar g = 0; g < TRI; g++) begin : g_fa
        fa_cell u_fa (
            .a  (bits[3*g]),
            .b  (bits[3*g+1]),
            .c  (bits[3*g+2]),
            .s  (sum[g]),
            .co (carry[g])
        );
    end
endmodule

// File: rtl/pipe_stage.sv
module pipe_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_data,
    output logic         out_vld,
    output logic [W-1:0] out_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/therm_ones_decoder.sv
module therm_ones_decoder
    import tdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [THERM_W-1:0]  therm_in,
    input  logic                therm_vld,
    output logic [CODE_W-1:0]   count_out,
    output logic                count_vld
);
    // ---------------- levels 1 and 2 (combinational from the input) ----------
    logic [L1_TRI-1:0] l1_w0, l1_w1;
    logic [L2_TRI-1:0] l2_s0, l2_c0, l2_s1, l2_c1;

    csa_row #(.TRI(L1_TRI)) u_l1_w0 (.bits(therm_in), .sum(l1_w0), .carry(l1_w1));
    csa_row #(.TRI(L2_TRI)) u_l2_w0 (.bits(l1_w0),    .sum(l2_s0), .carry(l2_c0));
    csa_row #(.TRI(L2_TRI)) u_l2_w1 (.bits(l1_w1),    .sum(l2_s1), .carry(l2_c1));

    // Stage 1 layout, low to high: weight1[7], weight2[14], weight4[7].
    logic            s1_vld;
    logic [S1_W-1:0] s1_q;

    pipe_stage #(.W(S1_W)) u_stage1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (therm_vld),
        .in_data  ({l2_c1, l2_c0, l2_s1, l2_s0}),
        .out_vld  (s1_vld),
        .out_data (s1_q)
    );

    logic [S1_W0-1:0] s1_w0;
    logic [S1_W1-1:0] s1_w1;
    logic [S1_W2-1:0] s1_w2;

    assign s1_w0 = s1_q[S1_W0-1:0];
    assign s1_w1 = s1_q[S1_W0+S1_W1-1:S1_W0];
    assign s1_w2 = s1_q[S1_W-1:S1_W0+S1_W1];

    // ---------------- levels 3 and 4 --------------------------------------
    logic [1:0] l3_s0, l3_c0, l3_s2, l3_c2;
    logic [3:0] l3_s1, l3_c1;

    csa_row #(.TRI(2)) u_l3_w0 (.bits(s1_w0[5:0]),  .sum(l3_s0), .carry(l3_c0));
    csa_row #(.TRI(4)) u_l3_w1 (.bits(s1_w1[11:0]), .sum(l3_s1), .carry(l3_c1));
    csa_row #(.TRI(2)) u_l3_w2 (.bits(s1_w2[5:0]),  .sum(l3_s2), .carry(l3_c2));

    logic [2:0] l3w0;
    logic [7:0] l3w1;
    logic [6:0] l3w2;
    logic [1:0] l3w3;

    assign l3w0 = {s1_w0[6], l3_s0};
    assign l3w1 = {l3_c0, s1_w1[13:12], l3_s1};
    assign l3w2 = {l3_c1, s1_w2[6], l3_s2};
    assign l3w3 = l3_c2;

    logic       l4_s0, l4_c0;
    logic [1:0] l4_s1, l4_c1, l4_s2, l4_c2;

    csa_row #(.TRI(1)) u_l4_w0 (.bits(l3w0),      .sum(l4_s0), .carry(l4_c0));
    csa_row #(.TRI(2)) u_l4_w1 (.bits(l3w1[5:0]), .sum(l4_s1), .carry(l4_c1));
    csa_row #(.TRI(2)) u_l4_w2 (.bits(l3w2[5:0]), .sum(l4_s2), .carry(l4_c2));

    logic [S2_W0-1:0] l4w0;
    logic [S2_W1-1:0] l4w1;
    logic [S2_W2-1:0] l4w2;
    logic [S2_W3-1:0] l4w3;

    assign l4w0 = l4_s0;
    assign l4w1 = {l4_c0, l3w1[7:6], l4_s1};
    assign l4w2 = {l4_c1, l3w2[6], l4_s2};
    assign l4w3 = {l4_c2, l3w3};

    // Stage 2 layout, low to high: weight1[1], weight2[5], weight4[5], weight8[4].
    logic            s2_vld;
    logic [S2_W-1:0] s2_q;

    pipe_stage #(.W(S2_W)) u_stage2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s1_vld),
        .in_data  ({l4w3, l4w2, l4w1, l4w0}),
        .out_vld  (s2_vld),
        .out_data (s2_q)
    );

    logic             s2w0;
    logic [S2_W1-1:0] s2w1;
    logic [S2_W2-1:0] s2w2;
    logic [S2_W3-1:0] s2w3;

    assign s2w0 = s2_q[0];
    assign s2w1 = s2_q[S2_W0+S2_W1-1:S2_W0];
    assign s2w2 = s2_q[S2_W0+S2_W1+S2_W2-1:S2_W0+S2_W1];
    assign s2w3 = s2_q[S2_W-1:S2_W0+S2_W1+S2_W2];

    // ---------------- levels 5 and 6 --------------------------------------
    logic l5_s1, l5_c1, l5_s2, l5_c2, l5_s3, l5_c3;

    csa_row #(.TRI(1)) u_l5_w1 (.bits(s2w1[2:0]), .sum(l5_s1), .carry(l5_c1));
    csa_row #(.TRI(1)) u_l5_w2 (.bits(s2w2[2:0]), .sum(l5_s2), .carry(l5_c2));
    csa_row #(.TRI(1)) u_l5_w3 (.bits(s2w3[2:0]), .sum(l5_s3), .carry(l5_c3));

    logic [2:0] l5w1;
    logic [3:0] l5w2;
    logic [2:0] l5w3;

    assign l5w1 = {s2w1[4:3], l5_s1};
    assign l5w2 = {l5_c1, s2w2[4:3], l5_s2};
    assign l5w3 = {l5_c2, s2w3[3], l5_s3};

    logic l6_s1, l6_c1, l6_s2, l6_c2, l6_s3, l6_c3;

    csa_row #(.TRI(1)) u_l6_w1 (.bits(l5w1),      .sum(l6_s1), .carry(l6_c1));
    csa_row #(.TRI(1)) u_l6_w2 (.bits(l5w2[2:0]), .sum(l6_s2), .carry(l6_c2));
    csa_row #(.TRI(1)) u_l6_w3 (.bits(l5w3),      .sum(l6_s3), .carry(l6_c3));

    // Stage 3 layout, low to high: weight1[1], weight2[1], weight4[3], weight8[2], weight16[2].
    logic            s3_vld;
    logic [S3_W-1:0] s3_q;

    pipe_stage #(.W(S3_W)) u_stage3 (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s2_vld),
        .in_data  ({l5_c3, l6_c3, l6_s3, l6_c2, l6_c1, l5w2[3], l6_s2, l6_s1, s2w0}),
        .out_vld  (s3_vld),
        .out_data (s3_q)
    );

    // ---------------- final carry-propagate merge -------------------------
    logic r2, r3, r4, r5, k3, k4;

    fa_cell u_cpa2 (.a(s3_q[2]), .b(s3_q[3]), .c(s3_q[4]), .s(r2), .co(k3));
    fa_cell u_cpa3 (.a(s3_q[5]), .b(s3_q[6]), .c(k3),      .s(r3), .co(k4));
    fa_cell u_cpa4 (.a(s3_q[7]), .b(s3_q[8]), .c(k4),      .s(r4), .co(r5));

    pipe_stage #(.W(CODE_W)) u_stage_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (s3_vld),
        .in_data  ({r5, r4, r3, r2, s3_q[1], s3_q[0]}),
        .out_vld  (count_vld),
        .out_data (count_out)
    );
endmodule

// File: rtl/tdec_chk.sv
module tdec_chk
    import tdec_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [THERM_W-1:0] therm_in,
    input logic               therm_vld,
    input logic [CODE_W-1:0]  count_out,
    input logic               count_vld,
    input logic               s1_vld,
    input logic [S1_W-1:0]    s1_bits,
    input logic               s2_vld,
    input logic [S2_W-1:0]    s2_bits,
    input logic               s3_vld,
    input logic [S3_W-1:0]    s3_bits
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    function automatic int s1_total(logic [S1_W-1:0] v);
        return $countones(v[6:0]) + 2 * $countones(v[20:7]) + 4 * $countones(v[27:21]);
    endfunction

    function automatic int s2_total(logic [S2_W-1:0] v);
        return $countones(v[0:0]) + 2 * $countones(v[5:1]) + 4 * $countones(v[10:6])
             + 8 * $countones(v[14:11]);
    endfunction

    function automatic int s3_total(logic [S3_W-1:0] v);
        return $countones(v[0:0]) + 2 * $countones(v[1:1]) + 4 * $countones(v[4:2])
             + 8 * $countones(v[6:5]) + 16 * $countones(v[8:7]);
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!count_vld && count_out == '0));

    // R3
    vld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (count_vld == $past(therm_vld, 4)));

    // R2
    out_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4 && count_vld) |-> (int'(count_out) == $countones($past(therm_in, 4))));

    // R2
    stage1_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && s1_vld) |-> (s1_total(s1_bits) == $countones($past(therm_in, 1))));

    // R2
    stage2_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && s2_vld) |-> (s2_total(s2_bits) == $countones($past(therm_in, 2))));

    // R2
    stage3_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd3 && s3_vld) |-> (s3_total(s3_bits) == $countones($past(therm_in, 3))));

    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd1 && !count_vld) |-> $stable(count_out));
endmodule

bind therm_ones_decoder tdec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .therm_in  (therm_in),
    .therm_vld (therm_vld),
    .count_out (count_out),
    .count_vld (count_vld),
    .s1_vld    (s1_vld),
    .s1_bits   (s1_q),
    .s2_vld    (s2_vld),
    .s2_bits   (s2_q),
    .s3_vld    (s3_vld),
    .s3_bits   (s3_q)
);

// File: tb/therm_ones_decoder_tb.sv
`timescale 1ns/1ps
module therm_ones_decoder_tb;
    localparam int W = 63;
    localparam real HALF = 4.0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] therm_in = '0;
    logic         therm_vld = 1'b0;
    logic [5:0]   count_out;
    logic         count_vld;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // four-deep line of expectations, index 3 is the oldest
    bit    hv [4];
    int    hc [4];
    string ht [4];
    int    last_cnt = 0;

    always #(HALF) clk = ~clk;

    therm_ones_decoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .therm_in  (therm_in),
        .therm_vld (therm_vld),
        .count_out (count_out),
        .count_vld (count_vld)
    );

    function automatic int ones(logic [W-1:0] w);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(w[i]);
        return n;
    endfunction

    function automatic logic [W-1:0] level(int k);
        logic [63:0] t;
        t = (64'd1 << k) - 64'd1;
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [63:0] t;
        t = {$urandom, $urandom};
        return t[W-1:0];
    endfunction

    task automatic step(bit v, logic [W-1:0] w, int e, string tag);
        bit ev;
        int ec;
        @(negedge clk);
        ev = hv[3];
        ec = ev ? hc[3] : last_cnt;
        if (ev) last_cnt = hc[3];
        total++;
        if (count_vld !== ev || count_out !== ec[5:0]) begin
            bad++;
            $display("FAIL %s: vld=%0b cnt=%0d expected vld=%0b cnt=%0d",
                     ht[3], count_vld, count_out, ev, ec);
        end
        for (int i = 3; i > 0; i--) begin
            hv[i] = hv[i-1];
            hc[i] = hc[i-1];
            ht[i] = ht[i-1];
        end
        hv[0] = v;
        hc[0] = e;
        ht[0] = tag;
        therm_vld = v;
        therm_in  = w;
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, rnd_word(), 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            hv[i] = 1'b0;
            hc[i] = 0;
            ht[i] = "R1";
        end
        // R1: inputs active during reset must not reach the outputs
        therm_vld = 1'b1;
        therm_in  = '1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            total++;
            if (count_vld !== 1'b0 || count_out !== 6'd0) begin
                bad++;
                $display("FAIL R1: vld=%0b cnt=%0d expected vld=0 cnt=0", count_vld, count_out);
            end
        end
        @(negedge clk);
        rst_n     = 1'b1;
        therm_vld = 1'b0;
        therm_in  = '0;

        idle(4, "R1");

        // R6: extremes
        step(1'b1, '0, 0, "R6");
        step(1'b1, '1, 63, "R6");
        step(1'b1, '0, 0, "R6");
        idle(4, "R6");

        // R3: isolated word, idle cycles around it must hold the value
        step(1'b1, level(37), 37, "R3");
        idle(6, "R3");
        step(1'b1, level(5), 5, "R3");
        idle(6, "R3");

        // R7: every clean level, back to back
        for (int k = 0; k <= 63; k++) step(1'b1, level(k), k, "R7");

        // R8: every single bubble at every level
        for (int k = 0; k <= 63; k++) begin
            for (int p = 0; p < W; p++) begin
                logic [W-1:0] w;
                w = level(k) ^ (63'd1 << p);
                step(1'b1, w, (p < k) ? k - 1 : k + 1, "R8");
            end
        end

        // R4: long unbroken burst of random words
        for (int i = 0; i < 600; i++) begin
            logic [W-1:0] w;
            w = rnd_word();
            step(1'b1, w, ones(w), "R4");
        end

        // R2 and R5: thermometer levels with several bubbles, random qualifier gaps
        for (int i = 0; i < 2000; i++) begin
            logic [W-1:0] w;
            w = level(int'($urandom_range(63)));
            for (int b = 0; b < int'($urandom_range(5)); b++)
                w[$urandom_range(W - 1)] ^= 1'b1;
            if ($urandom_range(3) == 0) step(1'b0, rnd_word(), 0, "R5");
            else                        step(1'b1, w, ones(w), "R2");
        end

        idle(8, "R5");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule